// File: doc/BRIEF.md
# ECG Baseline-Removal Feedback Integrator

This block is the digital half of a DC-offset removal loop for three ECG leads. The leads are digitised at the same instant. Each 8-bit unsigned sample is compared with the ADC mid-code 128, and the signed difference goes into a per-channel integrator that is always running. That integrator is scaled by a loop gain of 16 and drives a 15-bit correction word. A DAC outside the block turns the word into an offset voltage for the analog front end, which gives the loop a first-order high-pass response. A second integrator per channel runs only while samples sit on or beyond a programmable window near the ADC rails. It takes a larger step, so a channel driven into a rail is pulled back toward mid-range quickly.

A small controller with three named states sequences each sample. ST_IDLE waits for a valid sample. The transition ST_IDLE→ST_INTEG is taken when a sample is accepted and latched. The transition ST_INTEG→ST_DRIVE is unconditional, and both integrators are updated on it. The transition ST_DRIVE→ST_IDLE is unconditional, and the correction outputs are recomputed on it. Samples arrive at a few hundred per second, so the three-cycle pass never throttles the input.

Top module: `ecg_offset_loop`

## Requirements
- R1: After synchronous reset, every correction lane is 16384 (mid-scale), both integrators of every channel hold zero, and the window limits are low = 8 and high = 247.
- R2: For every accepted sample, the main integrator of each channel adds (sample − 128), whatever the sample value.
- R3: The fast integrator of a channel adds (sample − 128) × 2^FAST_SH only when sample ≤ low limit or sample ≥ high limit. Otherwise it keeps its value.
- R4: Both integrators saturate at −2^(ACC_W−1) and 2^(ACC_W−1)−1 and never wrap.
- R5: Correction = clamp(16384 + floor((main + fast) × 16 / 2^DROP), 0, 32767), computed per channel.
- R6: The correction outputs change only on the second rising edge after the edge that accepts a sample. At all other times they hold.
- R7: A samp_valid that is high while the controller is in ST_INTEG or ST_DRIVE is ignored.
- R8: Each channel has its own state. Channel k reads samp_data[8k+7:8k] and drives corr[15k+14:15k].
- R9: A clock edge with cfg_we high loads cfg_lo and cfg_hi as the new window limits. Later samples use them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| samp_valid | input | 1 | A new set of three simultaneous samples is present |
| samp_data | input | NCH*SMP_W | Packed samples, channel 0 in the low byte |
| cfg_we | input | 1 | Write strobe for the window limits |
| cfg_lo | input | SMP_W | New low window limit |
| cfg_hi | input | SMP_W | New high window limit |
| corr | output | NCH*OUT_W | Packed correction words, channel 0 in the low bits |

## Verification
The hardest state to reach from the ports is an integrator held at its saturation limit while the correction is also clamped. In that state a wrapping accumulator and a saturating one look the same until the signal walks back. The bench builds a small configuration (12-bit integrators, DROP = 1) in which a few dozen rail samples saturate both integrators. It then feeds samples from the opposite rail and checks every correction on the way back, so a wrapped state shows at once as the wrong clamp value. Sweeps over all 256 sample codes hit each window boundary with both the default and the written limits.

// File: rtl/ecg_loop_pkg.sv
`timescale 1ns/1ps
package ecg_loop_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_INTEG = 2'd1,
        ST_DRIVE = 2'd2
    } loop_st_e;
endpackage

// File: rtl/ecg_sat_integ.sv
`timescale 1ns/1ps
// Saturating accumulator: adds a signed error scaled by 2^SH when enabled.
module ecg_sat_integ #(
    parameter int W  = 24,
    parameter int EW = 10,
    parameter int SH = 0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic signed [EW-1:0] err,
    output logic signed [W-1:0]  acc
);
    localparam int SUMW = W + 1;
    localparam logic signed [SUMW-1:0] MAXV = {2'b00, {(W-1){1'b1}}};
    localparam logic signed [SUMW-1:0] MINV = {2'b11, {(W-1){1'b0}}};

    logic signed [SUMW-1:0] step;
    logic signed [SUMW-1:0] nxt;

    always_comb begin
        step = {{(SUMW-EW){err[EW-1]}}, err} <<< SH;
        nxt  = {acc[W-1], acc} + step;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
        end else if (en) begin
            if (nxt > MAXV)
                acc <= MAXV[W-1:0];
            else if (nxt < MINV)
                acc <= MINV[W-1:0];
            else
                acc <= nxt[W-1:0];
        end
    end
endmodule

// File: rtl/ecg_chan.sv
`timescale 1ns/1ps
// One lead: error formation, window detect, two integrators, scaled correction.
module ecg_chan #(
    parameter int SMP_W   = 8,
    parameter int ACC_W   = 24,
    parameter int OUT_W   = 15,
    parameter int GAIN_SH = 4,
    parameter int FAST_SH = 3,
    parameter int DROP    = 9
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    upd,
    input  logic                    drv,
    input  logic [SMP_W-1:0]        sample,
    input  logic [SMP_W-1:0]        lim_lo,
    input  logic [SMP_W-1:0]        lim_hi,
    output logic [OUT_W-1:0]        corr,
    output logic signed [ACC_W-1:0] macc,
    output logic signed [ACC_W-1:0] gacc,
    output logic                    outside
);
    localparam int EW   = SMP_W + 2;
    localparam int CW0  = ACC_W + GAIN_SH + 3;
    localparam int CW   = (CW0 > OUT_W + 2) ? CW0 : OUT_W + 2;
    localparam logic signed [EW-1:0] MIDS = EW'(1 << (SMP_W - 1));
    localparam logic signed [CW-1:0] MIDV = CW'(1 << (OUT_W - 1));
    localparam logic signed [CW-1:0] TOPV = CW'((1 << OUT_W) - 1);

    logic signed [EW-1:0] err;
    logic signed [CW-1:0] tot;
    logic signed [CW-1:0] scl;
    logic signed [CW-1:0] cand;
    logic [OUT_W-1:0]     corr_nxt;

    always_comb begin
        err     = $signed({2'b00, sample}) - MIDS;
        outside = (sample <= lim_lo) || (sample >= lim_hi);
    end

    ecg_sat_integ #(.W(ACC_W), .EW(EW), .SH(0)) u_main (
        .clk (clk),
        .rst (rst),
        .en  (upd),
        .err (err),
        .acc (macc)
    );

    ecg_sat_integ #(.W(ACC_W), .EW(EW), .SH(FAST_SH)) u_fast (
        .clk (clk),
        .rst (rst),
        .en  (upd && outside),
        .err (err),
        .acc (gacc)
    );

    always_comb begin
        tot  = {{(CW-ACC_W){macc[ACC_W-1]}}, macc}
             + {{(CW-ACC_W){gacc[ACC_W-1]}}, gacc};
        scl  = tot <<< GAIN_SH;
        cand = (scl >>> DROP) + MIDV;
        if (cand < 0)
            corr_nxt = '0;
        else if (cand > TOPV)
            corr_nxt = TOPV[OUT_W-1:0];
        else
            corr_nxt = cand[OUT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)
            corr <= MIDV[OUT_W-1:0];
        else if (drv)
            corr <= corr_nxt;
    end
endmodule

// File: rtl/ecg_loop_ctrl.sv
`timescale 1ns/1ps
// Per-sample sequencer: accept, integrate, drive.
module ecg_loop_ctrl
    import ecg_loop_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     valid,
    output loop_st_e st,
    output logic     accept,
    output logic     upd,
    output logic     drv
);
    loop_st_e st_nxt;

    always_ff @(posedge clk) begin
        if (rst)
            st <= ST_IDLE;
        else
            st <= st_nxt;
    end

    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_IDLE:  if (valid) st_nxt = ST_INTEG;
            ST_INTEG: st_nxt = ST_DRIVE;
            ST_DRIVE: st_nxt = ST_IDLE;
            default:  st_nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        accept = (st == ST_IDLE) && valid;
        upd    = (st == ST_INTEG);
        drv    = (st == ST_DRIVE);
    end
endmodule

// File: rtl/ecg_offset_loop.sv
`timescale 1ns/1ps
module ecg_offset_loop
    import ecg_loop_pkg::*;
#(
    parameter int NCH     = 3,
    parameter int SMP_W   = 8,
    parameter int ACC_W   = 24,
    parameter int OUT_W   = 15,
    parameter int GAIN_SH = 4,
    parameter int FAST_SH = 3,
    parameter int DROP    = 9,
    parameter int LO_DEF  = 8,
    parameter int HI_DEF  = 247
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   samp_valid,
    input  logic [NCH*SMP_W-1:0]   samp_data,
    input  logic                   cfg_we,
    input  logic [SMP_W-1:0]       cfg_lo,
    input  logic [SMP_W-1:0]       cfg_hi,
    output logic [NCH*OUT_W-1:0]   corr
);
    loop_st_e             st;
    logic                 accept;
    logic                 upd;
    logic                 drv;
    logic [SMP_W-1:0]     lim_lo;
    logic [SMP_W-1:0]     lim_hi;
    logic [NCH*SMP_W-1:0] smp_q;
    logic [NCH*ACC_W-1:0] macc_all;
    logic [NCH*ACC_W-1:0] gacc_all;
    logic [NCH-1:0]       out_all;

    ecg_loop_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .valid  (samp_valid),
        .st     (st),
        .accept (accept),
        .upd    (upd),
        .drv    (drv)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            lim_lo <= SMP_W'(LO_DEF);
            lim_hi <= SMP_W'(HI_DEF);
        end else if (cfg_we) begin
            lim_lo <= cfg_lo;
            lim_hi <= cfg_hi;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            smp_q <= '0;
        else if (accept)
            smp_q <= samp_data;
    end

    for (genvar k = 0; k < NCH; k++) begin : g_ch
        logic signed [ACC_W-1:0] macc_k;
        logic signed [ACC_W-1:0] gacc_k;

        ecg_chan #(
            .SMP_W   (SMP_W),
            .ACC_W   (ACC_W),
            .OUT_W   (OUT_W),
            .GAIN_SH (GAIN_SH),
            .FAST_SH (FAST_SH),
            .DROP    (DROP)
        ) u_ch (
            .clk     (clk),
            .rst     (rst),
            .upd     (upd),
            .drv     (drv),
            .sample  (smp_q[k*SMP_W +: SMP_W]),
            .lim_lo  (lim_lo),
            .lim_hi  (lim_hi),
            .corr    (corr[k*OUT_W +: OUT_W]),
            .macc    (macc_k),
            .gacc    (gacc_k),
            .outside (out_all[k])
        );

        assign macc_all[k*ACC_W +: ACC_W] = macc_k;
        assign gacc_all[k*ACC_W +: ACC_W] = gacc_k;
    end
endmodule

// File: rtl/ecg_offset_loop_chk.sv
`timescale 1ns/1ps
module ecg_offset_loop_chk
    import ecg_loop_pkg::*;
#(
    parameter int NCH   = 3,
    parameter int ACC_W = 24,
    parameter int OUT_W = 15
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 samp_valid,
    input loop_st_e             st,
    input logic [NCH*OUT_W-1:0] corr,
    input logic [NCH*ACC_W-1:0] macc_all,
    input logic [NCH*ACC_W-1:0] gacc_all,
    input logic [NCH-1:0]       out_all
);
    localparam logic [OUT_W-1:0] MIDC = OUT_W'(1 << (OUT_W - 1));

    // R2: main integrators move only in the integrate state
    assert_main_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (st != ST_INTEG) |=> $stable(macc_all));

    // R6: outputs move only in the drive state
    assert_corr_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (st != ST_DRIVE) |=> $stable(corr));

    assert_walk_R6: assert property (@(posedge clk) disable iff (rst)
        (st == ST_INTEG) |=> (st == ST_DRIVE));

    assert_take_R6: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && samp_valid) |=> (st == ST_INTEG));

    // R7: no new acceptance while busy
    assert_busy_ignore_R7: assert property (@(posedge clk) disable iff (rst)
        (st != ST_IDLE) |=> (st != ST_INTEG));

    for (genvar k = 0; k < NCH; k++) begin : g_lane
        // R3: fast integrator holds inside the window
        assert_gate_hold_R3: assert property (@(posedge clk) disable iff (rst)
            (st == ST_INTEG && !out_all[k]) |=> $stable(gacc_all[k*ACC_W +: ACC_W]));

        // R1: mid-scale right after reset
        assert_reset_mid_R1: assert property (@(posedge clk) disable iff (rst)
            $past(rst) |-> (corr[k*OUT_W +: OUT_W] == MIDC));
    end
endmodule

bind ecg_offset_loop ecg_offset_loop_chk #(
    .NCH   (NCH),
    .ACC_W (ACC_W),
    .OUT_W (OUT_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .samp_valid (samp_valid),
    .st         (st),
    .corr       (corr),
    .macc_all   (macc_all),
    .gacc_all   (gacc_all),
    .out_all    (out_all)
);

// File: tb/sim_ecg_offset_loop.sv
`timescale 1ns/1ps
module sim_ecg_offset_loop;
    localparam int NCH   = 3;
    localparam int ACCW  = 12;
    localparam int DRP   = 1;
    localparam int FSH   = 3;
    localparam longint AMAX = (64'sd1 <<< (ACCW - 1)) - 1;
    localparam longint AMIN = -(64'sd1 <<< (ACCW - 1));

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             samp_valid = 1'b0;
    logic [NCH*8-1:0] samp_data = '0;
    logic             cfg_we = 1'b0;
    logic [7:0]       cfg_lo = '0;
    logic [7:0]       cfg_hi = '0;
    logic [NCH*15-1:0] corr;

    int nvec  = 0;
    int nfail = 0;
    bit done  = 0;

    longint m_acc [NCH];
    longint g_acc [NCH];
    int     lo_m = 8;
    int     hi_m = 247;
    logic [14:0] exp_c [NCH];

    always #2.5 clk = ~clk;

    ecg_offset_loop #(
        .NCH   (NCH),
        .ACC_W (ACCW),
        .DROP  (DRP),
        .FAST_SH (FSH)
    ) u0 (
        .clk        (clk),
        .rst        (rst),
        .samp_valid (samp_valid),
        .samp_data  (samp_data),
        .cfg_we     (cfg_we),
        .cfg_lo     (cfg_lo),
        .cfg_hi     (cfg_hi),
        .corr       (corr)
    );

    function automatic longint sat(input longint v);
        if (v > AMAX) return AMAX;
        if (v < AMIN) return AMIN;
        return v;
    endfunction

    function automatic logic [14:0] model_corr(input int k);
        longint t;
        t = ((m_acc[k] + g_acc[k]) * 16) >>> DRP;
        t = t + 16384;
        if (t < 0) t = 0;
        if (t > 32767) t = 32767;
        return t[14:0];
    endfunction

    task automatic chk(input string req, input int lane, input logic [14:0] act, input logic [14:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s lane %0d actual %0d expected %0d", req, lane, act, exp);
        end
    endtask

    task automatic chk_all(input string req);
        for (int k = 0; k < NCH; k++) chk(req, k, corr[k*15 +: 15], exp_c[k]);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        samp_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        lo_m = 8;
        hi_m = 247;
        for (int k = 0; k < NCH; k++) begin
            m_acc[k] = 0;
            g_acc[k] = 0;
            exp_c[k] = 15'd16384;
        end
    endtask

    task automatic write_win(input int lo, input int hi);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_lo = 8'(lo);
        cfg_hi = 8'(hi);
        @(negedge clk);
        cfg_we = 1'b0;
        lo_m = lo;
        hi_m = hi;
    endtask

    // One sample set; hold keeps samp_valid high with other data while busy (R7).
    task automatic send(input int a, input int b, input int c, input bit hold, input string req);
        int s [NCH];
        s[0] = a; s[1] = b; s[2] = c;
        @(negedge clk);
        samp_data  = {8'(c), 8'(b), 8'(a)};
        samp_valid = 1'b1;
        @(negedge clk);                    // after accepting edge
        if (hold) samp_data = ~{8'(c), 8'(b), 8'(a)};
        else      samp_valid = 1'b0;
        chk_all("R6");
        @(negedge clk);                    // after integrate edge
        chk_all("R6");
        for (int k = 0; k < NCH; k++) begin
            longint e;
            e = longint'(s[k]) - 128;
            m_acc[k] = sat(m_acc[k] + e);
            if (s[k] <= lo_m || s[k] >= hi_m)
                g_acc[k] = sat(g_acc[k] + e * (64'sd1 <<< FSH));
            exp_c[k] = model_corr(k);
        end
        @(negedge clk);                    // after drive edge
        samp_valid = 1'b0;
        chk_all(req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    initial begin
        do_reset();
        chk_all("R1");

        // R1/R3: default window boundaries 8 and 247, inclusive on the rail side
        send(8, 9, 128, 1'b0, "R3");
        send(247, 246, 7, 1'b0, "R3");
        send(248, 128, 255, 1'b0, "R1");

        // R2 R5 R8: full sweep, independent lanes
        do_reset();
        for (int s = 0; s < 256; s++)
            send(s, 255 - s, 126 + (s % 5), 1'b0, "R5");

        // R9: written window limits
        do_reset();
        write_win(100, 150);
        for (int s = 0; s < 256; s++)
            send(s, (s * 7) % 256, s ^ 8'h55, 1'b0, "R9");

        // R4: drive to saturation and walk back
        do_reset();
        for (int i = 0; i < 40; i++) send(255, 0, 140, 1'b0, "R4");
        for (int i = 0; i < 60; i++) send(0, 255, 116, 1'b0, "R4");
        for (int i = 0; i < 40; i++) send(120, 136, 129, 1'b0, "R4");

        // R7: valid held high through the busy states
        do_reset();
        for (int i = 0; i < 20; i++) send(200 + i, 30 + i, 250, 1'b1, "R7");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule